// File: doc/BRIEF.md
# Dual-Target GPIO Interrupt Controller

This block manages a bank of general-purpose pins through a small word-addressed register file. Each line is either driven from a data-output register or sampled as an input. A per-line output-enable bit selects the mode, and a 1 in that bit makes the line an input. Input pins pass through a two-flop synchroniser. After that, rising-edge, falling-edge, low-level and high-level detectors feed two independent status registers. Each status register has its own enable mask and its own interrupt output, so two processors can each take interrupts from the same bank.

Software updates the enables, the wakeup mask and the data output either with whole-register writes or with write-1-to-set and write-1-to-clear aliases. Byte and half-word writes are steered into their byte lane. For ordinary registers they are merged with the bytes already held. A status bit whose line still meets a level condition is set again at once after software clears it. A wakeup pulse is raised for enabled lines when the system-configuration register allows wakeup and selects an idle mode. A system-configuration write can also soft-reset the whole block.

Top module: `dual_irq_gpio`

## Requirements
- R1: After reset, the registers read as follows: output enable (0x34) 0xFFFFFFFF, control (0x30) 2, identifier (0x00) 0x18, ready status (0x14) 1. Data out (0x3C), both status registers (0x18, 0x28) and the system configuration (0x10) read 0. irqA, irqB and wakeup are low.
- R2: pinOutEn is the inverse of the output-enable register, and pinOut equals the data-out register.
- R3: The data-in register (0x38) returns pinIn after two synchroniser stages. An event on a line sets that line's bit in both status registers (0x18 and 0x28) in the same cycle.
- R4: Only lines whose output-enable bit is 1 raise events. A rising edge counts when the line's bit in 0x48 is set, a falling edge when its bit in 0x4C is set, a low level when its bit in 0x40 is set, and a high level when its bit in 0x44 is set.
- R5: Writing to a status register clears the bits written as 1. irqA is the OR of (status 0x18 AND enable 0x1C), and irqB is the OR of (status 0x28 AND enable 0x2C).
- R6: A line that still meets an active level condition sets its status bit again in the cycle it is cleared, so it stays set.
- R7: Write-1 aliases: 0x60/0x64 clear/set enable 1, 0x70/0x74 clear/set enable 2, 0x80/0x84 clear/set wakeup enable (0x20), 0x90/0x94 clear/set data out. Reading an alias returns its underlying register.
- R8: A system-configuration write stores the value ANDed with 0x1D. If bit 1 of the value is set, every register returns to its R1 value first. The control register keeps only its 3 low bits.
- R9: wakeup pulses high in the cycle after an event on a line whose wakeup-enable bit is set. This happens only if system configuration bit 2 is 1 and bits [4:3] are nonzero.
- R10: busWrSize selects the write width: 0 for a byte, 1 for a half word, 2 for a word. Sub-word data is shifted into the lane given by busAddr[1:0]. Ordinary registers keep their other bytes. Status and alias registers take the shifted value with zeros in the other lanes.
- R11: Writes to 0x00, 0x14 and 0x38 have no effect. Reads of unmapped addresses return 0.
- R12: The debounce-enable register (0x50, full width) and the debounce-time register (0x54, 8 bits) hold what is written and affect nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address for reads and writes |
| busWrEn | input | 1 | Write strobe |
| busWrSize | input | 2 | Write width: 0 byte, 1 half word, 2 word |
| busWrData | input | 32 | Write data, right-aligned for narrow writes |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Pin output values |
| pinOutEn | output | 32 | Per-pin drive enable |
| irqA | output | 1 | Interrupt to the first target |
| irqB | output | 1 | Interrupt to the second target |
| wakeup | output | 1 | Wakeup pulse |

## Verification
The bench uses the default 32-line, 32-bit configuration, so every documented address and byte lane can be reached. A vector table walks edge-detect patterns in which the output enable masks off half the lines, and rising and falling detection are combined on interleaved bits. Directed tests then cover level re-latching across a clear, both interrupt outputs under independent enables, alias and sub-word lane writes, the wakeup qualification, read-only and unmapped addresses, and soft reset.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int REG_ADDR_W = 8;

  typedef enum logic [4:0] {
    SEL_NONE, SEL_REV, SEL_SYS, SEL_RDY, SEL_STA0, SEL_EN0, SEL_WU,
    SEL_STA1, SEL_EN1, SEL_CTL, SEL_OE, SEL_DIN, SEL_DOUT, SEL_LO,
    SEL_HI, SEL_RISE, SEL_FALL, SEL_DBEN, SEL_DBT
  } rdSel_e;

  typedef struct packed {
    logic wrSys;
    logic clrSta0;
    logic clrSta1;
    logic wrEn0;
    logic clrEn0;
    logic setEn0;
    logic wrEn1;
    logic clrEn1;
    logic setEn1;
    logic wrWu;
    logic clrWu;
    logic setWu;
    logic wrCtl;
    logic wrOe;
    logic wrOut;
    logic clrOut;
    logic setOut;
    logic wrLo;
    logic wrHi;
    logic wrRise;
    logic wrFall;
    logic wrDbEn;
    logic wrDbTime;
  } strobe_t;
endpackage

// File: rtl/gpio_dual_ctrl.sv
module gpio_dual_ctrl
  import gpio_dual_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [1:0]            busWrSize,
  input  logic [DATA_W-1:0]     busWrData,
  output strobe_t               strb,
  output logic [DATA_W-1:0]     laneData,
  output logic [DATA_W-1:0]     laneMask,
  output rdSel_e                rdSel
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LANE_W = $clog2(BYTES);

  logic [REG_ADDR_W-1:0] wordAddr;
  int laneOff;
  int laneCnt;
  logic [DATA_W-1:0] sizeMask;

  assign wordAddr = {busAddr[REG_ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign laneOff  = int'(busAddr[LANE_W-1:0]);

  always_comb begin
    case (busWrSize)
      2'd0:    begin laneCnt = 1; sizeMask = DATA_W'(8'hFF); end
      2'd1:    begin laneCnt = 2; sizeMask = DATA_W'(16'hFFFF); end
      default: begin laneCnt = BYTES; sizeMask = '1; end
    endcase
  end

  // per-lane byte selection for sub-word writes
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{(b >= laneOff) && (b < laneOff + laneCnt)}};
  end

  assign laneData = ((busWrData & sizeMask) << (8 * laneOff)) & laneMask;

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    case (wordAddr)
      8'h00: rdSel = SEL_REV;
      8'h10: begin rdSel = SEL_SYS;  strb.wrSys    = busWrEn; end
      8'h14: rdSel = SEL_RDY;
      8'h18: begin rdSel = SEL_STA0; strb.clrSta0  = busWrEn; end
      8'h1C: begin rdSel = SEL_EN0;  strb.wrEn0    = busWrEn; end
      8'h20: begin rdSel = SEL_WU;   strb.wrWu     = busWrEn; end
      8'h28: begin rdSel = SEL_STA1; strb.clrSta1  = busWrEn; end
      8'h2C: begin rdSel = SEL_EN1;  strb.wrEn1    = busWrEn; end
      8'h30: begin rdSel = SEL_CTL;  strb.wrCtl    = busWrEn; end
      8'h34: begin rdSel = SEL_OE;   strb.wrOe     = busWrEn; end
      8'h38: rdSel = SEL_DIN;
      8'h3C: begin rdSel = SEL_DOUT; strb.wrOut    = busWrEn; end
      8'h40: begin rdSel = SEL_LO;   strb.wrLo     = busWrEn; end
      8'h44: begin rdSel = SEL_HI;   strb.wrHi     = busWrEn; end
      8'h48: begin rdSel = SEL_RISE; strb.wrRise   = busWrEn; end
      8'h4C: begin rdSel = SEL_FALL; strb.wrFall   = busWrEn; end
      8'h50: begin rdSel = SEL_DBEN; strb.wrDbEn   = busWrEn; end
      8'h54: begin rdSel = SEL_DBT;  strb.wrDbTime = busWrEn; end
      8'h60: begin rdSel = SEL_EN0;  strb.clrEn0   = busWrEn; end
      8'h64: begin rdSel = SEL_EN0;  strb.setEn0   = busWrEn; end
      8'h70: begin rdSel = SEL_EN1;  strb.clrEn1   = busWrEn; end
      8'h74: begin rdSel = SEL_EN1;  strb.setEn1   = busWrEn; end
      8'h80: begin rdSel = SEL_WU;   strb.clrWu    = busWrEn; end
      8'h84: begin rdSel = SEL_WU;   strb.setWu    = busWrEn; end
      8'h90: begin rdSel = SEL_DOUT; strb.clrOut   = busWrEn; end
      8'h94: begin rdSel = SEL_DOUT; strb.setOut   = busWrEn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_dual_dp.sv
module gpio_dual_dp
  import gpio_dual_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] laneData,
  input  logic [DATA_W-1:0] laneMask,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pinOut,
  output logic [DATA_W-1:0] pinOutEn,
  output logic              irqA,
  output logic              irqB,
  output logic              wakeup
);
  localparam logic [4:0] SYS_KEEP = 5'h1D;
  localparam logic [2:0] CTL_INIT = 3'd2;

  logic [4:0] sysCfg;
  logic [2:0] ctlReg;
  logic [7:0] dbTime;
  logic [DATA_W-1:0] sta0, sta1, en0, en1, wuEn, oe, dataOut;
  logic [DATA_W-1:0] loDet, hiDet, riseDet, fallDet, dbEn;
  logic [DATA_W-1:0] sync1, syncIn, prevIn, evt, clrMask0, clrMask1, sysWrVal;

  function automatic logic [DATA_W-1:0] mergeIn(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] m,
                                                input logic [DATA_W-1:0] d);
    return (cur & ~m) | d;
  endfunction

  assign sysWrVal = mergeIn(DATA_W'(sysCfg), laneMask, laneData);
  assign clrMask0 = strb.clrSta0 ? laneData : '0;
  assign clrMask1 = strb.clrSta1 ? laneData : '0;

  // synchroniser and previous-sample stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      syncIn <= '0;
      prevIn <= '0;
    end else begin
      sync1  <= pinIn;
      syncIn <= sync1;
      prevIn <= syncIn;
    end
  end

  // per-line event detection
  for (genvar i = 0; i < DATA_W; i++) begin : g_evt
    assign evt[i] = oe[i] & ((riseDet[i] &  syncIn[i] & ~prevIn[i]) |
                             (fallDet[i] & ~syncIn[i] &  prevIn[i]) |
                             (hiDet[i]   &  syncIn[i]) |
                             (loDet[i]   & ~syncIn[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysCfg <= '0; ctlReg <= CTL_INIT; dbTime <= '0;
      sta0 <= '0; sta1 <= '0; en0 <= '0; en1 <= '0; wuEn <= '0;
      oe <= '1; dataOut <= '0; loDet <= '0; hiDet <= '0;
      riseDet <= '0; fallDet <= '0; dbEn <= '0; wakeup <= 1'b0;
    end else if (strb.wrSys && sysWrVal[1]) begin
      sysCfg <= sysWrVal[4:0] & SYS_KEEP; ctlReg <= CTL_INIT; dbTime <= '0;
      sta0 <= '0; sta1 <= '0; en0 <= '0; en1 <= '0; wuEn <= '0;
      oe <= '1; dataOut <= '0; loDet <= '0; hiDet <= '0;
      riseDet <= '0; fallDet <= '0; dbEn <= '0; wakeup <= 1'b0;
    end else begin
      if (strb.wrSys) sysCfg <= sysWrVal[4:0] & SYS_KEEP;
      sta0 <= (sta0 & ~clrMask0) | evt;
      sta1 <= (sta1 & ~clrMask1) | evt;
      wakeup <= sysCfg[2] && (sysCfg[4:3] != 2'b00) && ((evt & wuEn) != '0);
      if (strb.wrEn0)  en0 <= mergeIn(en0, laneMask, laneData);
      if (strb.clrEn0) en0 <= en0 & ~laneData;
      if (strb.setEn0) en0 <= en0 | laneData;
      if (strb.wrEn1)  en1 <= mergeIn(en1, laneMask, laneData);
      if (strb.clrEn1) en1 <= en1 & ~laneData;
      if (strb.setEn1) en1 <= en1 | laneData;
      if (strb.wrWu)   wuEn <= mergeIn(wuEn, laneMask, laneData);
      if (strb.clrWu)  wuEn <= wuEn & ~laneData;
      if (strb.setWu)  wuEn <= wuEn | laneData;
      if (strb.wrOut)  dataOut <= mergeIn(dataOut, laneMask, laneData);
      if (strb.clrOut) dataOut <= dataOut & ~laneData;
      if (strb.setOut) dataOut <= dataOut | laneData;
      if (strb.wrCtl)  ctlReg <= mergeIn(DATA_W'(ctlReg), laneMask, laneData)
                                 & DATA_W'(3'h7);
      if (strb.wrOe)   oe <= mergeIn(oe, laneMask, laneData);
      if (strb.wrLo)   loDet <= mergeIn(loDet, laneMask, laneData);
      if (strb.wrHi)   hiDet <= mergeIn(hiDet, laneMask, laneData);
      if (strb.wrRise) riseDet <= mergeIn(riseDet, laneMask, laneData);
      if (strb.wrFall) fallDet <= mergeIn(fallDet, laneMask, laneData);
      if (strb.wrDbEn) dbEn <= mergeIn(dbEn, laneMask, laneData);
      if (strb.wrDbTime) dbTime <= mergeIn(DATA_W'(dbTime), laneMask, laneData)
                                   & DATA_W'(8'hFF);
    end
  end

  assign irqA     = (sta0 & en0) != '0;
  assign irqB     = (sta1 & en1) != '0;
  assign pinOut   = dataOut;
  assign pinOutEn = ~oe;

  always_comb begin
    case (rdSel)
      SEL_REV:  rdData = DATA_W'(8'h18);
      SEL_SYS:  rdData = DATA_W'(sysCfg);
      SEL_RDY:  rdData = DATA_W'(1);
      SEL_STA0: rdData = sta0;
      SEL_EN0:  rdData = en0;
      SEL_WU:   rdData = wuEn;
      SEL_STA1: rdData = sta1;
      SEL_EN1:  rdData = en1;
      SEL_CTL:  rdData = DATA_W'(ctlReg);
      SEL_OE:   rdData = oe;
      SEL_DIN:  rdData = syncIn;
      SEL_DOUT: rdData = dataOut;
      SEL_LO:   rdData = loDet;
      SEL_HI:   rdData = hiDet;
      SEL_RISE: rdData = riseDet;
      SEL_FALL: rdData = fallDet;
      SEL_DBEN: rdData = dbEn;
      SEL_DBT:  rdData = DATA_W'(dbTime);
      default:  rdData = '0;
    endcase
  end

  // R4
  output_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sta0 & ~$past(sta0) & ~$past(oe)) == '0));

  // R3
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sta0 & ~$past(sta0) & ~sta1) == '0));

  // R5
  irq_a_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irqA) |-> $past(strb.clrSta0 || strb.wrEn0 || strb.clrEn0 || strb.wrSys));

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> $past(sysCfg[2] && (sysCfg[4:3] != 2'b00)));

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrSys && sysWrVal[1]) |=> (oe == '1 && ctlReg == CTL_INIT && sta0 == '0));
endmodule

// File: rtl/dual_irq_gpio.sv
module dual_irq_gpio
  import gpio_dual_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  input  logic [1:0]            busWrSize,
  input  logic [DATA_W-1:0]     busWrData,
  output logic [DATA_W-1:0]     busRdData,
  input  logic [DATA_W-1:0]     pinIn,
  output logic [DATA_W-1:0]     pinOut,
  output logic [DATA_W-1:0]     pinOutEn,
  output logic                  irqA,
  output logic                  irqB,
  output logic                  wakeup
);
  strobe_t strb;
  rdSel_e  rdSel;
  logic [DATA_W-1:0] laneData, laneMask;

  gpio_dual_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrSize(busWrSize),
    .busWrData(busWrData), .strb(strb), .laneData(laneData),
    .laneMask(laneMask), .rdSel(rdSel)
  );

  gpio_dual_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .laneData(laneData),
    .laneMask(laneMask), .rdSel(rdSel), .pinIn(pinIn), .rdData(busRdData),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqA(irqA), .irqB(irqB),
    .wakeup(wakeup)
  );
endmodule

// File: tb/dual_irq_gpio_tb.sv
`timescale 1ns/1ps
module dual_irq_gpio_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [1:0] busWrSize = 2'd2;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData, pinOut, pinOutEn;
  logic [31:0] pinIn = '0;
  logic irqA, irqB, wakeup;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_irq_gpio u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrSize(busWrSize), .busWrData(busWrData), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .irqA(irqA), .irqB(irqB), .wakeup(wakeup)
  );

  // fields: oe, rise, fall, before, after, expected status
  localparam logic [191:0] VEC [4] = '{
    {32'hFFFFFFFF, 32'h0000000F, 32'h00000000, 32'h00000000, 32'h000000FF, 32'h0000000F},
    {32'hFFFFFFFF, 32'h00000000, 32'hFF000000, 32'hFFFF0000, 32'h0000FFFF, 32'hFF000000},
    {32'h0000FFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h0000FFFF},
    {32'hFFFFFFFF, 32'h00FF00FF, 32'h00FF00FF, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h00FF00FF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrSize = sz; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrSize = 2'd2;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h34, r); check("R1 oe reset", r, 32'hFFFFFFFF);
    rd(8'h30, r); check("R1 ctl reset", r, 32'd2);
    rd(8'h00, r); check("R1 id", r, 32'h18);
    rd(8'h14, r); check("R1 ready", r, 32'h1);
    rd(8'h3C, r); check("R1 dout reset", r, 32'h0);
    rd(8'h18, r); check("R1 status0 reset", r, 32'h0);
    rd(8'h10, r); check("R1 sys reset", r, 32'h0);
    check("R1 outputs", {29'b0, irqA, irqB, wakeup}, 32'h0);
    check("R1 pinOutEn", pinOutEn, 32'h0);

    // R4 R3 table of edge patterns
    for (int v = 0; v < 4; v++) begin
      logic [31:0] vOe, vRise, vFall, vBefore, vAfter, vExp;
      {vOe, vRise, vFall, vBefore, vAfter, vExp} = VEC[v];
      wr(8'h48, 32'h0); wr(8'h4C, 32'h0); wr(8'h34, vOe);
      @(negedge clk); pinIn = vBefore;
      settle();
      wr(8'h48, vRise); wr(8'h4C, vFall);
      wr(8'h18, 32'hFFFFFFFF); wr(8'h28, 32'hFFFFFFFF);
      @(negedge clk); pinIn = vAfter;
      settle();
      rd(8'h18, r); check($sformatf("R4 edge vector %0d status0", v), r, vExp);
      rd(8'h28, r); check($sformatf("R3 edge vector %0d status1", v), r, vExp);
    end
    wr(8'h48, 32'h0); wr(8'h4C, 32'h0); wr(8'h34, 32'hFFFFFFFF);
    wr(8'h18, 32'hFFFFFFFF); wr(8'h28, 32'hFFFFFFFF);

    // R3 data in after synchroniser
    @(negedge clk); pinIn = 32'hA5A50F0F;
    settle();
    rd(8'h38, r); check("R3 data in", r, 32'hA5A50F0F);

    // R6 level re-latch
    @(negedge clk); pinIn = 32'h0;
    settle();
    wr(8'h40, 32'h00000020);
    settle();
    wr(8'h18, 32'h00000020);
    rd(8'h18, r); check("R6 low level held after clear", r, 32'h00000020);
    @(negedge clk); pinIn = 32'h00000020;
    settle();
    wr(8'h18, 32'hFFFFFFFF);
    rd(8'h18, r); check("R6 cleared once level gone", r, 32'h0);
    wr(8'h40, 32'h0); wr(8'h28, 32'hFFFFFFFF);

    // R5 two targets
    @(negedge clk); pinIn = 32'h0;
    settle();
    wr(8'h48, 32'h1);
    @(negedge clk); pinIn = 32'h1;
    settle();
    check("R5 masked irqs low", {30'b0, irqA, irqB}, 32'h0);
    wr(8'h64, 32'h1);
    #1 check("R5 irqA only", {30'b0, irqA, irqB}, 32'h2);
    wr(8'h74, 32'h1);
    #1 check("R5 both irqs", {30'b0, irqA, irqB}, 32'h3);
    wr(8'h60, 32'h1);
    #1 check("R7 clear enable drops irqA", {30'b0, irqA, irqB}, 32'h1);
    wr(8'h28, 32'h1);
    #1 check("R5 status clear drops irqB", {31'b0, irqB}, 32'h0);
    rd(8'h18, r); check("R5 status0 independent", r, 32'h1);
    rd(8'h70, r); check("R7 alias reads enable2", r, 32'h1);
    wr(8'h48, 32'h0); wr(8'h18, 32'hFFFFFFFF);

    // R2 pin drive
    wr(8'h34, 32'hFFFF0000);
    #1 check("R2 pinOutEn", pinOutEn, 32'h0000FFFF);
    wr(8'h3C, 32'h12345678);
    #1 check("R2 pinOut", pinOut, 32'h12345678);
    wr(8'h34, 32'hFFFFFFFF);

    // R7 data-out aliases, R10 alias lane not merged
    wr(8'h3C, 32'h000000F0);
    wr(8'h90, 32'h00000030);
    rd(8'h94, r); check("R7 clear dout alias", r, 32'h000000C0);
    wr(8'h95, 32'h01, 2'd0);
    rd(8'h3C, r); check("R10 alias byte lane", r, 32'h000001C0);
    wr(8'h84, 32'h8);
    rd(8'h80, r); check("R7 wake enable set alias", r, 32'h8);

    // R10 merged lanes, R12 debounce storage
    wr(8'h50, 32'h11223344);
    wr(8'h51, 32'hAA, 2'd0);
    rd(8'h50, r); check("R10 byte merge", r, 32'h1122AA44);
    wr(8'h52, 32'hBEEF, 2'd1);
    rd(8'h50, r); check("R10 half merge", r, 32'hBEEFAA44);
    wr(8'h54, 32'h1FF);
    rd(8'h54, r); check("R12 debounce time 8 bits", r, 32'hFF);
    rd(8'h18, r); check("R12 no status effect", r, 32'h0);

    // R11 read-only and unmapped
    wr(8'h00, 32'hDEADBEEF); wr(8'h14, 32'h0); wr(8'h38, 32'h0);
    rd(8'h00, r); check("R11 id unchanged", r, 32'h18);
    rd(8'h14, r); check("R11 ready unchanged", r, 32'h1);
    rd(8'h38, r); check("R11 data in unchanged", r, 32'h1);
    rd(8'h24, r); check("R11 unmapped 0x24", r, 32'h0);
    rd(8'h98, r); check("R11 unmapped 0x98", r, 32'h0);

    // R9 wakeup
    @(negedge clk); pinIn = 32'h0;
    settle();
    wr(8'h48, 32'h8);
    wr(8'h10, 32'h0C);
    rd(8'h10, r); check("R8 sys stored", r, 32'h0C);
    seen = 1'b0;
    @(negedge clk); pinIn = 32'h8;
    repeat (6) begin @(negedge clk); if (wakeup) seen = 1'b1; end
    check("R9 wakeup pulse", {31'b0, seen}, 32'h1);
    wr(8'h10, 32'h04);
    @(negedge clk); pinIn = 32'h0;
    settle();
    seen = 1'b0;
    @(negedge clk); pinIn = 32'h8;
    repeat (6) begin @(negedge clk); if (wakeup) seen = 1'b1; end
    check("R9 no wakeup without idle mode", {31'b0, seen}, 32'h0);

    // R8 control width and soft reset
    wr(8'h30, 32'hFF);
    rd(8'h30, r); check("R8 ctl 3 bits", r, 32'h7);
    wr(8'h34, 32'h0);
    wr(8'h10, 32'hFF);
    rd(8'h10, r); check("R8 sys masked", r, 32'h1D);
    rd(8'h34, r); check("R8 soft reset oe", r, 32'hFFFFFFFF);
    rd(8'h30, r); check("R8 soft reset ctl", r, 32'h2);
    rd(8'h3C, r); check("R8 soft reset dout", r, 32'h0);

    finish_run();
  end
endmodule